// File: doc/BRIEF.md
# Serial Flash Probe and Geometry Decoder

This block runs once after power-up, or whenever the system asks for it, to find out what kind of serial page-organised flash sits on a mode-0 SPI link. A single start pulse launches a fixed sequence of short chip-select frames. First comes an optional wake-up frame with its settling delay. Next is a three-byte identification read, and then repeated status reads until the device reports ready. The block accepts the device only when the vendor byte and the family field are the expected values. The capacity field is turned into a page-size exponent and a page count, which later blocks use to build flash addresses.

When the status register shows that the device still uses its non-power-of-two page layout, the probe sends the four-byte configuration sequence that switches it to power-of-two pages. It then ends with a distinct outcome, because the new layout only takes effect after a power cycle. In every case the result and the geometry stay fixed until the next accepted start pulse. Start pulses that arrive while a probe is running are ignored.

Top module: `fprobe_top`

## Requirements
- R1: After reset, spi_cs_n is high, spi_sclk is low, and busy, done, valid, error, reprog, page_shift, page_count, erase_bytes and erase_count are all zero. Whenever busy is low, spi_cs_n is high.
- R2: The link is SPI mode 0, most significant bit first, with spi_sclk idle low. When POWER_SAVE is nonzero, the first frame after start is the single byte 0xAB, and chip select then stays high for at least WAKE_CYCLES clock cycles before the next frame begins.
- R3: The identification frame is one chip-select frame: the byte 0x9F followed by three bytes read back (vendor, device byte 1, device byte 2).
- R4: The device is accepted only when the vendor byte is 0x1F, bits 7:5 of device byte 1 are 001, and the capacity code is known. Otherwise the probe ends with result 01 and error=1, with page_shift and page_count both 0, and no frame follows the identification frame.
- R5: Capacity code (device byte 1, bits 4:0) maps to (page_shift, page_count) as follows: 0x02 gives (8, 512), 0x03 gives (8, 1024), 0x04 gives (8, 2048), 0x05 gives (8, 4096), 0x06 gives (9, 4096), 0x07 gives (9, 8192), 0x08 gives (10, 8192). Every other code is unknown.
- R6: After acceptance, the block issues status frames, each the byte 0xD7 followed by one byte read back. It repeats them until bit 7 of the returned byte is 1.
- R7: If bit 0 of the ready status byte is 1, the result is 00 with valid=1 and the decoded geometry. If bit 0 is 0, one frame carries 0x3D 0x2A 0x80 0xA6, and the result is 10 with error=1, reprog=1 and zero geometry.
- R8: While valid is 1, erase_bytes equals 2 to the power page_shift and erase_count equals page_count.
- R9: At completion, done rises and busy falls. done, result, the flags and the geometry then hold their values until the next start pulse.
- R10: A start pulse while busy is 1 has no effect: the frame sequence and the result are those of the probe already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to run a probe |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| busy | output | 1 | Probe in progress |
| done | output | 1 | Probe finished; result is meaningful |
| result | output | 2 | 00 usable, 01 unknown device, 10 reconfigured, power cycle needed |
| valid | output | 1 | Geometry is usable |
| error | output | 1 | Probe did not yield a usable device |
| reprog | output | 1 | Page-size configuration was rewritten |
| page_shift | output | 4 | log2 of page size in bytes |
| page_count | output | 14 | Number of pages |
| erase_bytes | output | 11 | Erase unit size in bytes |
| erase_count | output | 14 | Number of erase units |

## Verification
A behavioural flash model on the bench answers the identification and status frames and logs every frame, so each probe is judged both by its outputs and by the exact frame sequence on the wire. Directed probes walk every known capacity code in power-of-two mode. Further directed probes cover a wrong vendor byte, a wrong family field, and codes just outside the known range; these separate acceptance from the capacity decode. Probes with several busy polls check that polling really waits for the ready bit. A probe whose device sits in the non-power-of-two layout exercises the reconfiguration path, and a start pulse injected mid-probe must not alter the logged frames. Seeded random identities, poll counts and page-mode bits then mix these paths.

// File: rtl/fprobe_pkg.sv
package fprobe_pkg;

    localparam int SHIFT_W  = 4;
    localparam int PAGES_W  = 14;
    localparam int EBYTES_W = 11;

    localparam logic [7:0] OP_WAKE     = 8'hAB;
    localparam logic [7:0] OP_IDREAD   = 8'h9F;
    localparam logic [7:0] OP_STATUS   = 8'hD7;
    localparam logic [7:0] FILL_BYTE   = 8'hFF;
    localparam logic [7:0] VENDOR_CODE = 8'h1F;
    localparam logic [2:0] FAMILY_CODE = 3'b001;

    typedef enum logic [1:0] {
        RES_OK      = 2'b00,
        RES_UNKNOWN = 2'b01,
        RES_REPROG  = 2'b10
    } result_e;

    typedef enum logic [1:0] {
        FR_WAKE,
        FR_ID,
        FR_POLL,
        FR_PROG
    } frame_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_GAP
    } state_e;

    typedef struct packed {
        logic               known;
        logic [SHIFT_W-1:0] shift;
        logic [PAGES_W-1:0] pages;
    } geom_t;

    // Capacity code to page geometry.
    function automatic geom_t cap_to_geom(input logic [4:0] cap);
        geom_t g;
        g = '0;
        g.known = 1'b1;
        case (cap)
            5'h02: begin g.shift = 4'd8;  g.pages = 14'd512;  end
            5'h03: begin g.shift = 4'd8;  g.pages = 14'd1024; end
            5'h04: begin g.shift = 4'd8;  g.pages = 14'd2048; end
            5'h05: begin g.shift = 4'd8;  g.pages = 14'd4096; end
            5'h06: begin g.shift = 4'd9;  g.pages = 14'd4096; end
            5'h07: begin g.shift = 4'd9;  g.pages = 14'd8192; end
            5'h08: begin g.shift = 4'd10; g.pages = 14'd8192; end
            default: g = '0;
        endcase
        return g;
    endfunction

    // Bytes that switch the device to power-of-two pages.
    function automatic logic [7:0] binmode_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    return 8'h3D;
            2'd1:    return 8'h2A;
            2'd2:    return 8'h80;
            default: return 8'hA6;
        endcase
    endfunction

    // Index of the final byte in each frame kind.
    function automatic logic [2:0] frame_last(input frame_e k);
        case (k)
            FR_WAKE: return 3'd0;
            FR_ID:   return 3'd3;
            FR_POLL: return 3'd1;
            default: return 3'd3;
        endcase
    endfunction

endpackage

// File: rtl/fprobe_spi_byte.sv
module fprobe_spi_byte #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx,
    output logic       fin,
    output logic       active
);

    localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_END = DIV_W'(HALF - 1);

    logic [DIV_W-1:0] div_q;
    logic [2:0]       bit_q;
    logic [7:0]       sh_q;
    logic [7:0]       rx_q;
    logic             sck_q;
    logic             act_q;
    logic             fin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            bit_q <= '0;
            sh_q  <= '0;
            rx_q  <= '0;
            sck_q <= 1'b0;
            act_q <= 1'b0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (!act_q) begin
                if (go) begin
                    act_q <= 1'b1;
                    sh_q  <= tx;
                    div_q <= '0;
                    bit_q <= '0;
                    sck_q <= 1'b0;
                end
            end else if (div_q == DIV_END) begin
                div_q <= '0;
                if (!sck_q) begin
                    // rising edge: sample the incoming bit
                    sck_q <= 1'b1;
                    rx_q  <= {rx_q[6:0], miso};
                end else begin
                    // falling edge: present the next outgoing bit
                    sck_q <= 1'b0;
                    sh_q  <= {sh_q[6:0], 1'b0};
                    if (bit_q == 3'd7) begin
                        act_q <= 1'b0;
                        fin_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign sclk   = sck_q;
    assign mosi   = sh_q[7];
    assign rx     = rx_q;
    assign fin    = fin_q;
    assign active = act_q;

endmodule

// File: rtl/fprobe_geom.sv
module fprobe_geom
    import fprobe_pkg::*;
(
    input  logic [7:0] vendor,
    input  logic [7:0] dev1,
    output logic       accept,
    output geom_t      geom
);

    geom_t raw;

    always_comb begin
        raw    = cap_to_geom(dev1[4:0]);
        accept = (vendor == VENDOR_CODE) && (dev1[7:5] == FAMILY_CODE) && raw.known;
        geom   = accept ? raw : '0;
    end

endmodule

// File: rtl/fprobe_timer.sv
module fprobe_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/fprobe_top.sv
module fprobe_top
    import fprobe_pkg::*;
#(
    parameter int SCK_HALF    = 2,
    parameter int POWER_SAVE  = 1,
    parameter int WAKE_CYCLES = 10000,
    parameter int FRAME_GAP   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    output logic                spi_sclk,
    output logic                spi_cs_n,
    output logic                spi_mosi,
    input  logic                spi_miso,
    output logic                busy,
    output logic                done,
    output logic [1:0]          result,
    output logic                valid,
    output logic                error,
    output logic                reprog,
    output logic [SHIFT_W-1:0]  page_shift,
    output logic [PAGES_W-1:0]  page_count,
    output logic [EBYTES_W-1:0] erase_bytes,
    output logic [PAGES_W-1:0]  erase_count
);

    localparam int     GAP_MAX = (WAKE_CYCLES > FRAME_GAP) ? WAKE_CYCLES : FRAME_GAP;
    localparam int     TMR_W   = $clog2(GAP_MAX + 1);
    localparam frame_e FIRST   = (POWER_SAVE != 0) ? FR_WAKE : FR_ID;

    state_e  st_q;
    frame_e  kind_q;
    logic [2:0] bidx_q;
    logic    kick_q;
    logic    cs_q;
    logic [7:0] vendor_q;
    logic [7:0] dev1_q;
    logic    sr_ready_q;
    logic    sr_binary_q;

    logic    done_q, valid_q, error_q, reprog_q;
    result_e result_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [PAGES_W-1:0] pages_q;

    // byte engine
    logic       eng_go;
    logic [7:0] eng_tx;
    logic [7:0] eng_rx;
    logic       eng_fin;
    logic       eng_active;
    logic       last_byte;

    // decode
    logic    id_accept;
    geom_t   id_geom;

    // gap timer
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;

    // next-step decision taken at the end of each gap
    logic    nx_finish;
    frame_e  nx_kind;
    result_e nx_result;

    fprobe_spi_byte #(.HALF(SCK_HALF)) u_byte (
        .clk    (clk),
        .rst    (rst),
        .go     (eng_go),
        .tx     (eng_tx),
        .miso   (spi_miso),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi),
        .rx     (eng_rx),
        .fin    (eng_fin),
        .active (eng_active)
    );

    fprobe_geom u_geom (
        .vendor (vendor_q),
        .dev1   (dev1_q),
        .accept (id_accept),
        .geom   (id_geom)
    );

    fprobe_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    assign eng_go    = (st_q == ST_FRAME) && kick_q && !eng_active;
    assign last_byte = (bidx_q == frame_last(kind_q));
    assign tmr_load  = (st_q == ST_FRAME) && eng_fin && last_byte;
    assign tmr_val   = (kind_q == FR_WAKE) ? TMR_W'(WAKE_CYCLES) : TMR_W'(FRAME_GAP);

    // outgoing byte for the current frame position
    always_comb begin
        eng_tx = FILL_BYTE;
        case (kind_q)
            FR_WAKE: eng_tx = OP_WAKE;
            FR_ID:   eng_tx = (bidx_q == 3'd0) ? OP_IDREAD : FILL_BYTE;
            FR_POLL: eng_tx = (bidx_q == 3'd0) ? OP_STATUS : FILL_BYTE;
            FR_PROG: eng_tx = binmode_byte(bidx_q[1:0]);
            default: eng_tx = FILL_BYTE;
        endcase
    end

    // what follows the frame that just closed
    always_comb begin
        nx_finish = 1'b0;
        nx_kind   = FR_ID;
        nx_result = RES_OK;
        case (kind_q)
            FR_WAKE: nx_kind = FR_ID;
            FR_ID: begin
                if (id_accept) begin
                    nx_kind = FR_POLL;
                end else begin
                    nx_finish = 1'b1;
                    nx_result = RES_UNKNOWN;
                end
            end
            FR_POLL: begin
                if (!sr_ready_q) begin
                    nx_kind = FR_POLL;
                end else if (sr_binary_q) begin
                    nx_finish = 1'b1;
                    nx_result = RES_OK;
                end else begin
                    nx_kind = FR_PROG;
                end
            end
            default: begin
                nx_finish = 1'b1;
                nx_result = RES_REPROG;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            kind_q      <= FR_ID;
            bidx_q      <= '0;
            kick_q      <= 1'b0;
            cs_q        <= 1'b1;
            vendor_q    <= '0;
            dev1_q      <= '0;
            sr_ready_q  <= 1'b0;
            sr_binary_q <= 1'b0;
            done_q      <= 1'b0;
            valid_q     <= 1'b0;
            error_q     <= 1'b0;
            reprog_q    <= 1'b0;
            result_q    <= RES_OK;
            shift_q     <= '0;
            pages_q     <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        done_q   <= 1'b0;
                        valid_q  <= 1'b0;
                        error_q  <= 1'b0;
                        reprog_q <= 1'b0;
                        result_q <= RES_OK;
                        shift_q  <= '0;
                        pages_q  <= '0;
                        st_q     <= ST_FRAME;
                        kind_q   <= FIRST;
                        bidx_q   <= '0;
                        kick_q   <= 1'b1;
                        cs_q     <= 1'b0;
                    end
                end
                ST_FRAME: begin
                    if (eng_go) begin
                        kick_q <= 1'b0;
                    end
                    if (eng_fin) begin
                        if (kind_q == FR_ID && bidx_q == 3'd1) vendor_q <= eng_rx;
                        if (kind_q == FR_ID && bidx_q == 3'd2) dev1_q   <= eng_rx;
                        if (kind_q == FR_POLL && bidx_q == 3'd1) begin
                            sr_ready_q  <= eng_rx[7];
                            sr_binary_q <= eng_rx[0];
                        end
                        if (last_byte) begin
                            cs_q <= 1'b1;
                            st_q <= ST_GAP;
                        end else begin
                            bidx_q <= bidx_q + 3'd1;
                            kick_q <= 1'b1;
                        end
                    end
                end
                default: begin
                    if (tmr_expired) begin
                        if (nx_finish) begin
                            st_q     <= ST_IDLE;
                            done_q   <= 1'b1;
                            result_q <= nx_result;
                            valid_q  <= (nx_result == RES_OK);
                            error_q  <= (nx_result != RES_OK);
                            reprog_q <= (nx_result == RES_REPROG);
                            if (nx_result == RES_OK) begin
                                shift_q <= id_geom.shift;
                                pages_q <= id_geom.pages;
                            end
                        end else begin
                            st_q   <= ST_FRAME;
                            kind_q <= nx_kind;
                            bidx_q <= '0;
                            kick_q <= 1'b1;
                            cs_q   <= 1'b0;
                        end
                    end
                end
            endcase
        end
    end

    assign spi_cs_n    = cs_q;
    assign busy        = (st_q != ST_IDLE);
    assign done        = done_q;
    assign result      = result_q;
    assign valid       = valid_q;
    assign error       = error_q;
    assign reprog      = reprog_q;
    assign page_shift  = shift_q;
    assign page_count  = pages_q;
    assign erase_bytes = valid_q ? (EBYTES_W'(1) << shift_q) : '0;
    assign erase_count = pages_q;

endmodule

// File: rtl/fprobe_chk.sv
module fprobe_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        spi_sclk,
    input logic        spi_cs_n,
    input logic        busy,
    input logic        done,
    input logic [1:0]  result,
    input logic        valid,
    input logic        error,
    input logic        reprog,
    input logic [3:0]  page_shift,
    input logic [13:0] page_count
);

    // R2: serial clock rests low while the device is deselected
    a_r2_sclk_low_deselected: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    // R1: no frame open outside a probe
    a_r1_cs_high_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> spi_cs_n);

    // R4: only the three defined result codes appear
    a_r4_result_legal: assert property (@(posedge clk) disable iff (rst)
        done |-> result != 2'b11);

    // R7: exactly one outcome class is flagged
    a_r7_one_outcome: assert property (@(posedge clk) disable iff (rst)
        done |-> $onehot({valid, reprog, error && !reprog}));

    // R5: usable geometry is within the decoded range
    a_r5_geom_range: assert property (@(posedge clk) disable iff (rst)
        valid |-> (page_count != 14'd0) && (page_shift >= 4'd8) && (page_shift <= 4'd10));

    // R9: results hold until a new start
    a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done && $stable(result) && $stable(page_count) && $stable(page_shift));

    // R9: busy and done never overlap
    a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

endmodule

bind fprobe_top fprobe_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .spi_sclk   (spi_sclk),
    .spi_cs_n   (spi_cs_n),
    .busy       (busy),
    .done       (done),
    .result     (result),
    .valid      (valid),
    .error      (error),
    .reprog     (reprog),
    .page_shift (page_shift),
    .page_count (page_count)
);

// File: tb/tb_fprobe_top.sv
`timescale 1ns/1ps
module tb_fprobe_top;

    localparam int HALF = 2;
    localparam int WAKE = 40;
    localparam int GAP  = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        spi_sclk, spi_cs_n, spi_mosi;
    logic        spi_miso;
    logic        busy, done, valid, error, reprog;
    logic [1:0]  result;
    logic [3:0]  page_shift;
    logic [13:0] page_count;
    logic [10:0] erase_bytes;
    logic [13:0] erase_count;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    fprobe_top #(
        .SCK_HALF    (HALF),
        .POWER_SAVE  (1),
        .WAKE_CYCLES (WAKE),
        .FRAME_GAP   (GAP)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .spi_sclk    (spi_sclk),
        .spi_cs_n    (spi_cs_n),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .busy        (busy),
        .done        (done),
        .result      (result),
        .valid       (valid),
        .error       (error),
        .reprog      (reprog),
        .page_shift  (page_shift),
        .page_count  (page_count),
        .erase_bytes (erase_bytes),
        .erase_count (erase_count)
    );

    // ---------------- flash model ----------------
    logic [7:0] m_vendor, m_dev1, m_dev2;
    int         m_busy_polls;
    bit         m_binary;
    bit         model_on = 1'b0;
    int         bits;
    logic [7:0] shin;
    int         fcount;
    int         status_reads;
    int         flen  [0:63];
    logic [7:0] fb    [0:63][0:3];
    longint     ffall [0:63];
    longint     frise [0:63];
    longint     cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] resp_byte(input int k);
        logic [7:0] op;
        op = (fcount < 64) ? fb[fcount][0] : 8'h00;
        if (k == 0) return 8'h00;
        if (op == 8'h9F) begin
            if (k == 1) return m_vendor;
            if (k == 2) return m_dev1;
            if (k == 3) return m_dev2;
            return 8'hFF;
        end
        if (op == 8'hD7) begin
            return {(status_reads >= m_busy_polls), 6'b0, m_binary};
        end
        return 8'h00;
    endfunction

    always @(negedge spi_cs_n) begin
        if (model_on) begin
            bits = 0;
            spi_miso = 1'b0;
            if (fcount < 64) ffall[fcount] = cyc;
        end
    end

    always @(posedge spi_sclk) begin
        if (model_on && !spi_cs_n) begin
            shin = {shin[6:0], spi_mosi};
            bits = bits + 1;
            if (bits % 8 == 0 && bits / 8 <= 4 && fcount < 64)
                fb[fcount][bits/8-1] = shin;
        end
    end

    always @(negedge spi_sclk) begin
        if (model_on && !spi_cs_n) begin
            logic [7:0] b;
            b = resp_byte(bits / 8);
            spi_miso = b[7 - (bits % 8)];
        end
    end

    always @(posedge spi_cs_n) begin
        if (model_on) begin
            if (fcount < 64) begin
                flen[fcount]  = bits / 8;
                frise[fcount] = cyc;
                if (fb[fcount][0] == 8'hD7 && bits >= 16) status_reads = status_reads + 1;
            end
            fcount = fcount + 1;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic exp_geom(input logic [7:0] ven, input logic [7:0] d1,
                            output bit ok, output int sh, output int pg);
        ok = 1; sh = 0; pg = 0;
        case (d1[4:0])
            5'd2: begin sh = 8;  pg = 512;  end
            5'd3: begin sh = 8;  pg = 1024; end
            5'd4: begin sh = 8;  pg = 2048; end
            5'd5: begin sh = 8;  pg = 4096; end
            5'd6: begin sh = 9;  pg = 4096; end
            5'd7: begin sh = 9;  pg = 8192; end
            5'd8: begin sh = 10; pg = 8192; end
            default: ok = 0;
        endcase
        if (ven != 8'h1F || d1[7:5] != 3'b001) ok = 0;
        if (!ok) begin sh = 0; pg = 0; end
    endtask

    task automatic run_probe(input logic [7:0] ven, input logic [7:0] d1,
                             input int polls, input bit binary, input bit inject);
        bit ok; int sh; int pg; int exp_frames; int exp_res; int bad; int n;
        logic [1:0] res_hold; logic [13:0] pg_hold;
        m_vendor = ven; m_dev1 = d1; m_dev2 = 8'h01;
        m_busy_polls = polls; m_binary = binary;
        fcount = 0; status_reads = 0;
        for (int i = 0; i < 64; i++) begin
            flen[i] = 0;
            for (int j = 0; j < 4; j++) fb[i][j] = 8'h00;
        end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (inject) begin
            repeat (30) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end

        exp_geom(ven, d1, ok, sh, pg);
        exp_res    = !ok ? 1 : (binary ? 0 : 2);
        exp_frames = 2 + (ok ? (polls + 1 + (binary ? 0 : 1)) : 0);

        chk("R9 done after probe", done, 1);
        chk("R9 busy low after probe", busy, 0);
        chk("R4/R7 result code", result, exp_res);
        chk("R7 valid flag", valid, exp_res == 0);
        chk("R4 error flag", error, exp_res != 0);
        chk("R7 reprog flag", reprog, exp_res == 2);
        chk("R5 page_shift", page_shift, (exp_res == 0) ? sh : 0);
        chk("R5 page_count", page_count, (exp_res == 0) ? pg : 0);
        if (exp_res == 0) begin
            chk("R8 erase_bytes", erase_bytes, 1 << sh);
            chk("R8 erase_count", erase_count, pg);
        end
        if (inject) chk("R10 frames with ignored start", fcount, exp_frames);
        else        chk("R4/R6 frame count", fcount, exp_frames);

        chk("R2 wake frame opcode", fb[0][0], 8'hAB);
        chk("R2 wake frame length", flen[0], 1);
        chk("R2 wake delay honoured", (ffall[1] - frise[0]) >= WAKE, 1);
        chk("R3 id opcode", fb[1][0], 8'h9F);
        chk("R3 id frame length", flen[1], 4);
        if (ok) begin
            bad = 0;
            for (int f = 2; f < 3 + polls; f++)
                if (fb[f][0] != 8'hD7 || flen[f] != 2) bad++;
            chk("R6 status frames well formed", bad, 0);
            if (!binary) begin
                chk("R7 prog frame length", flen[3+polls], 4);
                chk("R7 prog byte 0", fb[3+polls][0], 8'h3D);
                chk("R7 prog byte 1", fb[3+polls][1], 8'h2A);
                chk("R7 prog byte 2", fb[3+polls][2], 8'h80);
                chk("R7 prog byte 3", fb[3+polls][3], 8'hA6);
            end
        end

        res_hold = result; pg_hold = page_count;
        repeat (12) @(negedge clk);
        chk("R9 result held", result, res_hold);
        chk("R9 geometry held", page_count, pg_hold);
        chk("R9 done held", done, 1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int seed_val;
        seed_val = $urandom(32'd4242);
        rst = 1'b1; start = 1'b0; spi_miso = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 cs_n after reset", spi_cs_n, 1);
        chk("R1 sclk after reset", spi_sclk, 0);
        chk("R1 busy after reset", busy, 0);
        chk("R1 done after reset", done, 0);
        chk("R1 flags after reset", {valid, error, reprog}, 0);
        chk("R1 geometry after reset", page_count, 0);
        chk("R1 erase size after reset", erase_bytes, 0);
        model_on = 1'b1;

        // R5: every known capacity code, binary mode
        for (int c = 2; c <= 8; c++) run_probe(8'h1F, {3'b001, 5'(c)}, 0, 1'b1, 1'b0);
        // R4: vendor and family mismatches, out-of-range codes
        run_probe(8'h1E, 8'h26, 0, 1'b1, 1'b0);
        run_probe(8'h1F, 8'h46, 0, 1'b1, 1'b0);
        run_probe(8'h1F, 8'h21, 0, 1'b1, 1'b0);
        run_probe(8'h1F, 8'h29, 0, 1'b1, 1'b0);
        // R6: several busy polls
        run_probe(8'h1F, 8'h27, 3, 1'b1, 1'b0);
        // R7: non-binary layout triggers reconfiguration
        run_probe(8'h1F, 8'h26, 1, 1'b0, 1'b0);
        // R10: start pulse during a probe
        run_probe(8'h1F, 8'h28, 2, 1'b1, 1'b1);

        // seeded random mix
        for (int r = 0; r < 24; r++) begin
            logic [7:0] ven; logic [7:0] d1;
            ven = ($urandom % 8 == 0) ? 8'($urandom) : 8'h1F;
            d1  = ($urandom % 6 == 0) ? 8'($urandom) : {3'b001, 5'(1 + $urandom % 9)};
            run_probe(ven, d1, $urandom % 3, ($urandom % 4) != 0, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule